// File: doc/BRIEF.md
# Sparse Row Cluster Encoder

This block compresses one row of binary pixel hits into a short list of 16-bit words. A row of 512 hit bits arrives with its 8-bit row address. The row is cut into 8 banks of 64 columns, and all banks are searched in the same cycle. Within a bank, every run of adjacent hits is cut into clusters of at most 4 pixels. Each bank keeps a bounded number of clusters. The bank lists are then joined into one row list that also has a cap. A row with at least one hit is sent as a header word followed by one word per kept cluster. A row with no hits sends nothing.

Rows come in on a `row_valid`/`row_ready` pair. A row is taken only in a cycle where both are high. `row_ready` is low from the cycle after a row is taken until the last word of that row has left. Words leave on an `out_valid`/`out_ready` stream, with `out_last` marking the final word of a row. The consumer may hold `out_ready` low for any length of time. While it does, the offered word, its last marker and the valid flag stay as they are, and nothing is lost. Each word takes one cycle when `out_ready` stays high. A row with N kept clusters therefore occupies the block for N+2 cycles, and the row period must allow for this.

Top module: `zsr_row_encoder`

## Requirements
- R1: Bank b covers columns 64*b to 64*b+63. A run of hits that crosses a bank edge is cut at that edge, and each side forms its own clusters.
- R2: A cluster is 1 to 4 adjacent hit columns. A longer run is cut into pieces of 4 starting from its lowest column, and any remainder forms the final piece.
- R3: A bank keeps its 6 lowest-column clusters (parameter BANK_CAP) and drops the rest.
- R4: The joined row list takes bank 0's clusters first and bank 7's last, and keeps at most 12 (parameter ROW_CAP, up to 15). Later clusters are dropped.
- R5: Header word layout: bits 3:0 hold the number of cluster words that follow, bits 11:4 hold the row address, bit 12 is the overflow flag, and bits 15:13 are zero.
- R6: Cluster word layout: bits 2:0 hold the pixel count (1 to 4), bits 11:3 hold the absolute start column (0 to 511), and bits 15:12 are zero.
- R7: The overflow flag is 1 exactly when some bank had more than BANK_CAP clusters or the joined total exceeded ROW_CAP.
- R8: A row with no hits produces no words, and `row_ready` stays high.
- R9: The header comes first. Cluster words follow in ascending column order. `out_last` is high on the final word of the row and on no other word.
- R10: A row is taken only when `row_valid` and `row_ready` are both high. `row_ready` is low from the cycle after a row is taken until that row's last word transfers. A `row_valid` pulse during this time is ignored.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values.
- R12: The header is offered in the cycle after the row is taken. With `out_ready` held high, one word transfers per cycle. `row_ready` is high again in the cycle after the last transfer.
- R13: After reset, `out_valid` is low and `row_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | A row is offered |
| row_ready | output | 1 | The encoder is idle and can take a row |
| row_addr | input | 8 | Address of the offered row |
| row_hits | input | 512 | One hit bit per column; bit c is column c |
| out_valid | output | 1 | A word is offered |
| out_ready | input | 1 | The consumer takes the offered word |
| out_data | output | 16 | Header or cluster word |
| out_last | output | 1 | The offered word is the row's final word |

## Verification
The header is due in the first cycle after the edge that takes the row, because the bank results are registered at that edge. Each later word is due one edge after the previous transfer, and `row_ready` returns one edge after the final transfer. The bench drives inputs on the falling edge and samples outputs on the falling edge that follows each rising edge it counts. It treats a word as transferred only when it saw `out_valid` and itself held `out_ready` at that sample. This lets it check, under both steady and irregular back-pressure, that each word arrives in the cycle it is due.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

  localparam int WORD_W = 16;
  localparam int CNT_W  = 4;
  localparam int ROWA_W = 8;
  localparam int COLA_W = 9;
  localparam int LEN_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_BODY
  } zsr_state_e;

  // Row header: overflow at bit 12, row address in 11:4, count in 3:0
  function automatic logic [WORD_W-1:0] make_header(
    input logic [CNT_W-1:0]  cnt,
    input logic [ROWA_W-1:0] row,
    input logic              ovf
  );
    make_header = {3'b000, ovf, row, cnt};
  endfunction

  // Cluster word: start column in 11:3, pixel count in 2:0
  function automatic logic [WORD_W-1:0] make_cluster(
    input logic [COLA_W-1:0] col,
    input logic [LEN_W-1:0]  len
  );
    make_cluster = {4'b0000, col, len};
  endfunction

endpackage

// File: rtl/zsr_bank_finder.sv
module zsr_bank_finder #(
  parameter int BANK_W   = 64,
  parameter int BANK_CAP = 6,
  parameter int MAX_RUN  = 4,
  localparam int LCOL_W  = $clog2(BANK_W),
  localparam int SLOT_W  = $clog2(BANK_CAP + 1),
  localparam int RUN_W   = $clog2(MAX_RUN + 1)
) (
  input  logic [BANK_W-1:0]                           hits,
  output logic [SLOT_W-1:0]                           n_found,
  output logic                                        dropped,
  output logic [BANK_CAP-1:0][LCOL_W-1:0]             start_col,
  output logic [BANK_CAP-1:0][zsr_pkg::LEN_W-1:0]     run_len
);

  logic [SLOT_W-1:0]                       cnt_v;
  logic                                    drop_v;
  logic                                    kept_v;
  logic [RUN_W-1:0]                        run_v;
  logic [BANK_CAP-1:0][LCOL_W-1:0]         col_v;
  logic [BANK_CAP-1:0][zsr_pkg::LEN_W-1:0] len_v;

  // Walk the columns from low to high. run_v is the position inside the
  // current cluster; reaching MAX_RUN forces a new cluster.
  always_comb begin
    cnt_v  = '0;
    drop_v = 1'b0;
    kept_v = 1'b0;
    run_v  = '0;
    col_v  = '0;
    len_v  = '0;
    for (int c = 0; c < BANK_W; c++) begin
      if (hits[c]) begin
        if (run_v == '0 || run_v == RUN_W'(MAX_RUN)) begin
          run_v = RUN_W'(1);
          if (cnt_v < SLOT_W'(BANK_CAP)) begin
            col_v[cnt_v] = LCOL_W'(c);
            len_v[cnt_v] = zsr_pkg::LEN_W'(1);
            cnt_v        = cnt_v + SLOT_W'(1);
            kept_v       = 1'b1;
          end else begin
            drop_v = 1'b1;
            kept_v = 1'b0;
          end
        end else begin
          run_v = run_v + RUN_W'(1);
          if (kept_v) begin
            len_v[cnt_v - SLOT_W'(1)] = len_v[cnt_v - SLOT_W'(1)] + zsr_pkg::LEN_W'(1);
          end
        end
      end else begin
        run_v = '0;
      end
    end
  end

  assign n_found   = cnt_v;
  assign dropped   = drop_v;
  assign start_col = col_v;
  assign run_len   = len_v;

endmodule

// File: rtl/zsr_row_merge.sv
module zsr_row_merge #(
  parameter int NBANK    = 8,
  parameter int BANK_W   = 64,
  parameter int BANK_CAP = 6,
  parameter int ROW_CAP  = 12,
  localparam int LCOL_W  = $clog2(BANK_W),
  localparam int SLOT_W  = $clog2(BANK_CAP + 1),
  localparam int SUM_W   = $clog2(NBANK * BANK_CAP + 1)
) (
  input  logic [NBANK-1:0][SLOT_W-1:0]                         bank_n,
  input  logic [NBANK-1:0]                                     bank_drop,
  input  logic [NBANK-1:0][BANK_CAP-1:0][LCOL_W-1:0]           bank_col,
  input  logic [NBANK-1:0][BANK_CAP-1:0][zsr_pkg::LEN_W-1:0]   bank_len,
  input  logic [zsr_pkg::CNT_W-1:0]                            pick,
  output logic [zsr_pkg::CNT_W-1:0]                            row_total,
  output logic                                                 row_ovf,
  output logic [zsr_pkg::WORD_W-1:0]                           pick_word
);

  logic [NBANK-1:0][SUM_W-1:0] offs;
  logic [SUM_W-1:0]            acc;
  logic [SUM_W-1:0]            total_raw;
  logic [SUM_W-1:0]            pk;
  logic [SLOT_W-1:0]           sl;
  logic [zsr_pkg::COLA_W-1:0]  col_abs;

  // Running offsets: first joined index owned by each bank
  always_comb begin
    acc = '0;
    for (int b = 0; b < NBANK; b++) begin
      offs[b] = acc;
      acc     = acc + SUM_W'(bank_n[b]);
    end
    total_raw = acc;
  end

  assign row_total = (total_raw > SUM_W'(ROW_CAP)) ? zsr_pkg::CNT_W'(ROW_CAP)
                                                   : zsr_pkg::CNT_W'(total_raw);
  assign row_ovf   = (|bank_drop) || (total_raw > SUM_W'(ROW_CAP));

  // Pick the joined entry at index pick from the bank that owns it
  always_comb begin
    pk        = SUM_W'(pick);
    sl        = '0;
    col_abs   = '0;
    pick_word = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (pk >= offs[b] && pk < offs[b] + SUM_W'(bank_n[b])) begin
        sl        = SLOT_W'(pk - offs[b]);
        col_abs   = zsr_pkg::COLA_W'(b * BANK_W) + zsr_pkg::COLA_W'(bank_col[b][sl]);
        pick_word = zsr_pkg::make_cluster(col_abs, bank_len[b][sl]);
      end
    end
  end

endmodule

// File: rtl/zsr_out_ctrl.sv
module zsr_out_ctrl (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [zsr_pkg::CNT_W-1:0]  row_total,
  input  logic                       out_ready,
  output logic                       is_head,
  output logic [zsr_pkg::CNT_W-1:0]  pick,
  output logic                       out_valid,
  output logic                       out_last,
  output logic                       row_ready
);

  zsr_pkg::zsr_state_e        state_q;
  logic [zsr_pkg::CNT_W-1:0]  pick_q;
  logic                       body_last;

  assign body_last = (pick_q == row_total - zsr_pkg::CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= zsr_pkg::ST_IDLE;
      pick_q  <= '0;
    end else begin
      case (state_q)
        zsr_pkg::ST_IDLE: begin
          pick_q <= '0;
          if (start) state_q <= zsr_pkg::ST_HEAD;
        end
        zsr_pkg::ST_HEAD: begin
          if (out_ready) state_q <= zsr_pkg::ST_BODY;
        end
        zsr_pkg::ST_BODY: begin
          if (out_ready) begin
            if (body_last) begin
              state_q <= zsr_pkg::ST_IDLE;
              pick_q  <= '0;
            end else begin
              pick_q <= pick_q + zsr_pkg::CNT_W'(1);
            end
          end
        end
        default: state_q <= zsr_pkg::ST_IDLE;
      endcase
    end
  end

  assign is_head   = (state_q == zsr_pkg::ST_HEAD);
  assign pick      = pick_q;
  assign out_valid = (state_q != zsr_pkg::ST_IDLE);
  assign out_last  = (state_q == zsr_pkg::ST_BODY) && body_last;
  assign row_ready = (state_q == zsr_pkg::ST_IDLE);

endmodule

// File: rtl/zsr_row_encoder.sv
module zsr_row_encoder #(
  parameter int NBANK    = 8,
  parameter int BANK_W   = 64,
  parameter int BANK_CAP = 6,
  parameter int ROW_CAP  = 12,
  parameter int MAX_RUN  = 4,
  localparam int NCOL    = NBANK * BANK_W,
  localparam int LCOL_W  = $clog2(BANK_W),
  localparam int SLOT_W  = $clog2(BANK_CAP + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        row_valid,
  output logic                        row_ready,
  input  logic [zsr_pkg::ROWA_W-1:0]  row_addr,
  input  logic [NCOL-1:0]             row_hits,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [zsr_pkg::WORD_W-1:0]  out_data,
  output logic                        out_last
);

  logic accept;

  logic [NBANK-1:0][SLOT_W-1:0]                        bn_d, bn_q;
  logic [NBANK-1:0]                                    bd_d, bd_q;
  logic [NBANK-1:0][BANK_CAP-1:0][LCOL_W-1:0]          bc_d, bc_q;
  logic [NBANK-1:0][BANK_CAP-1:0][zsr_pkg::LEN_W-1:0]  bl_d, bl_q;
  logic [zsr_pkg::ROWA_W-1:0]                          row_q;

  logic [zsr_pkg::CNT_W-1:0]  row_total;
  logic                       row_ovf;
  logic [zsr_pkg::WORD_W-1:0] pick_word;
  logic [zsr_pkg::CNT_W-1:0]  pick;
  logic                       is_head;

  assign accept = row_valid && row_ready;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    zsr_bank_finder #(
      .BANK_W  (BANK_W),
      .BANK_CAP(BANK_CAP),
      .MAX_RUN (MAX_RUN)
    ) u_find (
      .hits     (row_hits[g*BANK_W +: BANK_W]),
      .n_found  (bn_d[g]),
      .dropped  (bd_d[g]),
      .start_col(bc_d[g]),
      .run_len  (bl_d[g])
    );
  end

  // Bank results and row address are held for the whole output of a row
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bn_q  <= '0;
      bd_q  <= '0;
      bc_q  <= '0;
      bl_q  <= '0;
      row_q <= '0;
    end else if (accept) begin
      bn_q  <= bn_d;
      bd_q  <= bd_d;
      bc_q  <= bc_d;
      bl_q  <= bl_d;
      row_q <= row_addr;
    end
  end

  zsr_row_merge #(
    .NBANK   (NBANK),
    .BANK_W  (BANK_W),
    .BANK_CAP(BANK_CAP),
    .ROW_CAP (ROW_CAP)
  ) u_merge (
    .bank_n   (bn_q),
    .bank_drop(bd_q),
    .bank_col (bc_q),
    .bank_len (bl_q),
    .pick     (pick),
    .row_total(row_total),
    .row_ovf  (row_ovf),
    .pick_word(pick_word)
  );

  zsr_out_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && (|row_hits)),
    .row_total(row_total),
    .out_ready(out_ready),
    .is_head  (is_head),
    .pick     (pick),
    .out_valid(out_valid),
    .out_last (out_last),
    .row_ready(row_ready)
  );

  assign out_data = is_head ? zsr_pkg::make_header(row_total, row_q, row_ovf) : pick_word;

endmodule

// File: rtl/zsr_checker.sv
module zsr_checker #(
  parameter int ROW_CAP = 12,
  parameter int MAX_RUN = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        row_valid,
  input logic        row_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        out_last
);

  logic       first_word;
  logic [3:0] hdr_cnt;
  logic [3:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_word <= 1'b1;
      hdr_cnt    <= '0;
      beats      <= '0;
    end else if (out_valid && out_ready) begin
      if (first_word) begin
        first_word <= 1'b0;
        hdr_cnt    <= out_data[3:0];
        beats      <= '0;
      end else begin
        beats <= beats + 4'd1;
        if (out_last) first_word <= 1'b1;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    row_ready |-> !out_valid);

  assert_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && first_word |-> out_data[15:13] == 3'b000 && out_data[3:0] != 4'd0
                                && out_data[3:0] <= 4'(ROW_CAP) && !out_last);

  assert_cluster_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !first_word |-> out_data[15:12] == 4'd0 && out_data[2:0] != 3'd0
                                 && out_data[2:0] <= 3'(MAX_RUN));

  assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> !first_word && (beats + 4'd1) == hdr_cnt);

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && row_ready && !out_valid |=> !(out_valid && !first_word));

endmodule

bind zsr_row_encoder zsr_checker #(
  .ROW_CAP(ROW_CAP),
  .MAX_RUN(MAX_RUN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .row_valid(row_valid),
  .row_ready(row_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/sim_zsr_row_encoder.sv
module sim_zsr_row_encoder;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         row_valid = 1'b0;
  logic         row_ready;
  logic [7:0]   row_addr = '0;
  logic [511:0] row_hits = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [15:0]  out_data;
  logic         out_last;

  int n_chk = 0;
  int n_fail = 0;

  int exp_w [0:15];
  int exp_n;
  int exp_hdr;

  always #(CLK_PERIOD/2) clk = ~clk;

  zsr_row_encoder u0 (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_ready(row_ready),
    .row_addr(row_addr), .row_hits(row_hits), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected words from run lengths: each run cut into pieces of 4
  task automatic build_expect(input logic [511:0] h, input logic [7:0] a);
    int total_raw, ovf, c, len, rem, bc;
    total_raw = 0; ovf = 0; exp_n = 0;
    for (int b = 0; b < 8; b++) begin
      bc = 0; c = 0;
      while (c < 64) begin
        if (h[b*64 + c]) begin
          len = 0;
          while (c + len < 64 && h[b*64 + c + len]) len++;
          for (int off = 0; off < len; off += 4) begin
            rem = (len - off > 4) ? 4 : len - off;
            if (bc < 6) begin
              bc++; total_raw++;
              if (exp_n < 12) begin
                exp_w[exp_n] = ((b*64 + c + off) << 3) | rem;
                exp_n++;
              end
            end else ovf = 1;
          end
          c += len;
        end else c++;
      end
    end
    if (total_raw > 12) ovf = 1;
    exp_hdr = (ovf << 12) | (int'(a) << 4) | exp_n;
  endtask

  // Send a row, then collect and compare its words
  task automatic run_row(input logic [511:0] h, input logic [7:0] a,
                         input bit stall, input bit inject, input string tag);
    int idx, guard;
    bit done, rdy;
    logic [7:0] lf;
    build_expect(h, a);
    @(negedge clk);
    chk(row_ready === 1'b1, {tag, " R10 ready before row"}, row_ready, 1);
    row_valid = 1'b1; row_hits = h; row_addr = a;
    @(negedge clk);
    row_valid = 1'b0;
    if (exp_n == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(out_valid === 1'b0 && row_ready === 1'b1, "R8 empty row silent",
            {out_valid, row_ready}, 1);
        @(negedge clk);
      end
      return;
    end
    chk(out_valid === 1'b1, "R12 header due one cycle after accept", out_valid, 1);
    idx = 0; done = 0; guard = 0; lf = 8'h5a ^ a;
    while (!done) begin
      if (inject && guard == 0) begin
        row_valid = 1'b1; row_hits = ~h; row_addr = ~a;
      end else row_valid = 1'b0;
      rdy = stall ? lf[0] | lf[3] : 1'b1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (idx == 0)
          chk(out_data === 16'(exp_hdr), {tag, " R5 R7 header"}, out_data, exp_hdr);
        else
          chk(out_data === 16'(exp_w[idx-1]), {tag, " R6 R9 cluster"}, out_data, exp_w[idx-1]);
        chk(out_last === (idx == exp_n), "R9 last marker", out_last, idx == exp_n);
        if (idx == exp_n || out_last) done = 1;
        idx++;
      end
      @(negedge clk);
      if (!done && !stall)
        chk(out_valid === 1'b1, "R12 one word per cycle", out_valid, 1);
      guard++;
      if (guard > 300) begin
        chk(0, "R12 row never finished", idx, exp_n + 1);
        done = 1;
      end
    end
    row_valid = 1'b0;
    out_ready = 1'b0;
    chk(row_ready === 1'b1 && out_valid === 1'b0, "R12 ready after last",
        {row_ready, out_valid}, 2);
    if (inject) begin
      for (int i = 0; i < 4; i++) @(negedge clk);
      chk(out_valid === 1'b0, "R10 row offered while busy ignored", out_valid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && row_ready === 1'b1, "R13 reset state",
        {out_valid, row_ready}, 1);

    // R1 R2: every pattern straddling the bank 0 / bank 1 edge
    for (int p = 0; p < 256; p++) begin
      h = '0; h[60 +: 8] = 8'(p);
      run_row(h, 8'(p), (p % 7) == 0, 1'b0, "R1 R2 edge sweep");
    end

    // R2: runs of every length from column 0 and ending at column 511
    for (int L = 1; L <= 13; L++) begin
      h = '0;
      for (int i = 0; i < L; i++) h[i] = 1'b1;
      run_row(h, 8'd1, 1'b0, 1'b0, "R2 run at low edge");
      h = '0;
      for (int i = 0; i < L; i++) h[511 - i] = 1'b1;
      run_row(h, 8'd255, 1'b1, 1'b0, "R2 run at high edge");
    end

    // R8: empty row
    run_row('0, 8'd7, 1'b0, 1'b0, "R8 empty");

    // R3 R7: 6 then 7 isolated hits in bank 2
    h = '0; for (int i = 0; i < 6; i++) h[128 + 3*i] = 1'b1;
    run_row(h, 8'd20, 1'b0, 1'b0, "R3 bank at cap");
    h[128 + 18] = 1'b1;
    run_row(h, 8'd21, 1'b0, 1'b0, "R3 R7 bank over cap");
    h = '0; for (int i = 0; i < 32; i++) h[192 + 2*i] = 1'b1;
    run_row(h, 8'd22, 1'b1, 1'b0, "R3 R7 dense bank");

    // R4 R7: 12 then 13 clusters over three banks
    h = '0;
    for (int i = 0; i < 6; i++) begin h[64 + 5*i] = 1'b1; h[320 + 5*i] = 1'b1; end
    run_row(h, 8'd30, 1'b0, 1'b0, "R4 row at cap");
    h[500] = 1'b1;
    run_row(h, 8'd31, 1'b0, 1'b0, "R4 R7 row over cap");
    run_row('1, 8'd32, 1'b1, 1'b0, "R4 R7 full row");

    // R9: one hit per bank, order across banks
    h = '0; for (int b = 0; b < 8; b++) h[b*64 + 63 - b] = 1'b1;
    run_row(h, 8'd40, 1'b0, 1'b0, "R9 bank order");

    // R10 R11: busy-time offer and irregular back-pressure
    h = '0; h[10 +: 6] = '1; h[300 +: 3] = '1;
    run_row(h, 8'd50, 1'b1, 1'b1, "R10 R11 inject");
    run_row(h, 8'd51, 1'b0, 1'b1, "R10 inject no stall");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule